// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel

A single timer channel on a small 32-bit register bus. Software loads a start count and an interval, picks one of two tick inputs and a power-of-two divider, and sets the run bit. Each divided tick lowers the count by one. When the count expires, a status bit is set and an interrupt can be raised. In periodic mode the count reloads from the interval and keeps running. In one-shot mode the channel stops at zero and clears its own run bit.

The start count and the interval are written through separate registers. This lets the first timeout differ from the period that follows. The status bit is cleared by writing 1 to it, and it stays set until software does so. Registers sit at word addresses. Byte offset = 4 × word address.

Top module: `dcnt_timer`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: Register words: 0x00 interrupt enable (bit 0), 0x01 status (bit 0), 0x04 control, 0x05 interval, 0x06 current count. Read data appears on `rdata_o` the cycle after `rd_en_i` and is 0 otherwise. Unused bits and unmapped words read as 0.
- R3: Reading word 0x06 returns the live count. Writing word 0x06 sets the count for the next timeout without touching the interval.
- R4: Control bit 0 is the run bit. The count changes only on a divided tick while the run bit is 1, and it holds in every other cycle.
- R5: Control bit 2 selects the tick source: 0 takes `tick_slow_i`, 1 takes `tick_fast_i`. The tick that is not selected has no effect.
- R6: Control bits [6:4] hold N. One divided tick is produced for every 2^N selected ticks, on the last tick of each group. Any write to the control register restarts the divider phase.
- R7: A divided tick that meets a count of 1 or 0 is an expiry, and it sets status bit 0 on the next cycle.
- R8: With control bit 1 set (periodic), an expiry loads the interval into the count and the channel keeps running, so the period equals the interval in divided ticks.
- R9: With control bit 1 clear (one-shot), an expiry leaves the count at 0 and clears the run bit. Further ticks then have no effect.
- R10: Writing 1 to status bit 0 clears it, and writing 0 has no effect. An expiry in the same cycle as the clearing write wins, and the bit stays set.
- R11: `irq_o` is high exactly while status bit 0 and enable bit 0 are both 1.
- R12: A write to the current count in the same cycle as a divided tick takes priority. The written value is loaded and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| tick_slow_i | input | 1 | Tick source 0 (count enable pulse) |
| tick_fast_i | input | 1 | Tick source 1 (count enable pulse) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases are the same-cycle collisions. In one, an expiring tick meets a write that clears the status bit. In the other, a tick meets a write to the current count while the count sits at 1. To reach them, the stimulus first steps the count down to 1 with single ticks whose effect is known. It then raises the tick and the write strobe on the same negative edge. Afterwards it reads back the status and the count to see which side won. A second hard case is the divider phase. A control write must clear it, so the test counts the exact tick on which the divided count first moves.

// File: rtl/dcnt_timer_pkg.sv
package dcnt_timer_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;

  localparam logic [AW-1:0] A_IEN = 6'h00;
  localparam logic [AW-1:0] A_STS = 6'h01;
  localparam logic [AW-1:0] A_CTL = 6'h04;
  localparam logic [AW-1:0] A_IVL = 6'h05;
  localparam logic [AW-1:0] A_CUR = 6'h06;

  localparam int unsigned B_RUN = 0;
  localparam int unsigned B_ARL = 1;
  localparam int unsigned B_SRC = 2;
  localparam int unsigned B_PSC = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_IEN, SEL_STS, SEL_CTL, SEL_IVL, SEL_CUR
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    case (a)
      A_IEN:   return SEL_IEN;
      A_STS:   return SEL_STS;
      A_CTL:   return SEL_CTL;
      A_IVL:   return SEL_IVL;
      A_CUR:   return SEL_CUR;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dcnt_prescale.sv
module dcnt_prescale #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             src_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  output logic             dec_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] mask;
  logic             tick;

  assign tick  = run_i && (src_i ? tick_fast_i : tick_slow_i);
  assign mask  = ~({DIV_W{1'b1}} << psc_i);
  // last tick of each 2^N group
  assign dec_o = tick && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pcnt_q <= '0;
    else if (clr_i || !run_i)  pcnt_q <= '0;
    else if (tick)             pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic             arl_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] ival_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q <= CNT_W'(1));
  assign expire_o = dec_i && !ld_i && last;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
    end else if (dec_i) begin
      if (last) cnt_q <= arl_i ? ival_i : '0;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dcnt_regs.sv
module dcnt_regs
  import dcnt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ien_o,
  output logic             sts_o,
  output logic             run_o,
  output logic             arl_o,
  output logic             src_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] ival_o,
  output logic             ld_o,
  output logic             ctl_wr_o,
  output logic [DW-1:0]    rdata_o
);
  reg_sel_e         sel;
  logic             wr_ien, wr_sts, wr_ctl, wr_ivl;
  logic             ien_q, sts_q, run_q, arl_q, src_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] ival_q;
  logic [DW-1:0]    ctl_rd, rd_mux, rdata_q;

  assign sel    = decode(addr_i);
  assign wr_ien = wr_en_i && (sel == SEL_IEN);
  assign wr_sts = wr_en_i && (sel == SEL_STS);
  assign wr_ctl = wr_en_i && (sel == SEL_CTL);
  assign wr_ivl = wr_en_i && (sel == SEL_IVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= 1'b0;
      sts_q  <= 1'b0;
      ival_q <= '0;
    end else begin
      if (wr_ien) ien_q <= wdata_i[0];
      // set beats clear
      if (expire_i)                    sts_q <= 1'b1;
      else if (wr_sts && wdata_i[0])   sts_q <= 1'b0;
      if (wr_ivl) ival_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      arl_q <= 1'b0;
      src_q <= 1'b0;
      psc_q <= '0;
    end else if (wr_ctl) begin
      run_q <= wdata_i[B_RUN];
      arl_q <= wdata_i[B_ARL];
      src_q <= wdata_i[B_SRC];
      psc_q <= wdata_i[B_PSC +: PSC_W];
    end else if (expire_i && !arl_q) begin
      run_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_rd                  = '0;
    ctl_rd[B_RUN]           = run_q;
    ctl_rd[B_ARL]           = arl_q;
    ctl_rd[B_SRC]           = src_q;
    ctl_rd[B_PSC +: PSC_W]  = psc_q;
  end

  always_comb begin
    unique case (sel)
      SEL_IEN: rd_mux = DW'(ien_q);
      SEL_STS: rd_mux = DW'(sts_q);
      SEL_CTL: rd_mux = ctl_rd;
      SEL_IVL: rd_mux = DW'(ival_q);
      SEL_CUR: rd_mux = DW'(cnt_i);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en_i ? rd_mux : '0;
  end

  assign ien_o    = ien_q;
  assign sts_o    = sts_q;
  assign run_o    = run_q;
  assign arl_o    = arl_q;
  assign src_o    = src_q;
  assign psc_o    = psc_q;
  assign ival_o   = ival_q;
  assign ld_o     = wr_en_i && (sel == SEL_CUR);
  assign ctl_wr_o = wr_ctl;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_slow_i,
  input  logic          tick_fast_i,
  output logic          irq_o
);
  logic             ien_w, sts_w, run_w, arl_w, src_w;
  logic [PSC_W-1:0] psc_w;
  logic [CNT_W-1:0] ival_w, cnt_w;
  logic             ld_w, ctl_wr_w, dec_w, expire_w;

  dcnt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .expire_i (expire_w),
    .cnt_i    (cnt_w),
    .ien_o    (ien_w),
    .sts_o    (sts_w),
    .run_o    (run_w),
    .arl_o    (arl_w),
    .src_o    (src_w),
    .psc_o    (psc_w),
    .ival_o   (ival_w),
    .ld_o     (ld_w),
    .ctl_wr_o (ctl_wr_w),
    .rdata_o  (rdata_o)
  );

  dcnt_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .clr_i       (ctl_wr_w),
    .src_i       (src_w),
    .psc_i       (psc_w),
    .tick_slow_i (tick_slow_i),
    .tick_fast_i (tick_fast_i),
    .dec_o       (dec_w)
  );

  dcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (dec_w),
    .arl_i    (arl_w),
    .ld_i     (ld_w),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .ival_i   (ival_w),
    .cnt_o    (cnt_w),
    .expire_o (expire_w)
  );

  assign irq_o = sts_w && ien_w;
endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk
  import dcnt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic             wdata0_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] ival_w,
  input logic             sts_w,
  input logic             run_w,
  input logic             arl_w,
  input logic             dec_w,
  input logic             expire_w
);
  a_r4_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !(wr_en_i && addr_i == A_CUR)) |=> $stable(cnt_w));

  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_w && cnt_w > CNT_W'(1) && !wr_en_i) |=> cnt_w == $past(cnt_w) - CNT_W'(1));

  a_r7_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> sts_w);

  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_w && arl_w && !wr_en_i) |=> cnt_w == $past(ival_w));

  a_r9_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_w && !arl_w && !wr_en_i) |=> (!run_w && cnt_w == '0));

  a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STS && wdata0_i && !expire_w) |=> !sts_w);

  a_r11_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IEN && !wdata0_i) |=> !irq_o);
endmodule

bind dcnt_timer dcnt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata0_i (wdata_i[0]),
  .irq_o    (irq_o),
  .cnt_w    (cnt_w),
  .ival_w   (ival_w),
  .sts_w    (sts_w),
  .run_w    (run_w),
  .arl_w    (arl_w),
  .dec_w    (dec_w),
  .expire_w (expire_w)
);

// File: tb/dcnt_timer_bench.sv
module dcnt_timer_bench;
  localparam logic [5:0] W_IEN = 6'h00, W_STS = 6'h01, W_CTL = 6'h04,
                         W_IVL = 6'h05, W_CUR = 6'h06;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_slow_i = 1'b0, tick_fast_i = 1'b0;
  logic        irq_o;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic rd_d;
  exp_t sb[$];

  always #10ns clk_i = ~clk_i;

  dcnt_timer u_dcnt_timer (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .tick_slow_i, .tick_fast_i, .irq_o
  );

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_d <= 1'b0;
    else         rd_d <= rd_en_i;

  // monitor: compare read data against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rd_d) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected read data %h, got %h exp none", rdata_o, rdata_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rdata_o !== e.val) begin
          n_fail++;
          $display("FAIL %s: got %h exp %h", e.tag, rdata_o, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sb.push_back(e);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic tick(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      if (fast) tick_fast_i = 1'b1; else tick_slow_i = 1'b1;
      @(negedge clk_i);
      tick_fast_i = 1'b0; tick_slow_i = 1'b0;
    end
  endtask

  task automatic tick_wr(input logic [5:0] a, input logic [31:0] d);
    tick_slow_i = 1'b1; wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    tick_slow_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_bit(irq_o, 1'b0, "R1 irq in reset");
    chk_bit(|rdata_o, 1'b0, "R1 rdata in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values
    rd(W_IEN, 0, "R1 ien"); rd(W_STS, 0, "R1 sts"); rd(W_CTL, 0, "R1 ctl");
    rd(W_IVL, 0, "R1 ivl"); rd(W_CUR, 0, "R1 cur");
    chk_bit(|rdata_o, 1'b0, "R2 rdata idle zero");
    // R2 map and readback
    wr(W_IEN, 32'hFFFF_FFFF); rd(W_IEN, 1, "R2 ien");
    wr(W_CTL, 32'hFFFF_FFF6); rd(W_CTL, 32'h76, "R2 ctl fields");
    wr(W_IVL, 32'hA5A5_0000); rd(W_IVL, 32'hA5A5_0000, "R2 ivl");
    rd(6'h02, 0, "R2 unmapped");
    // R3 load current independently
    wr(W_CUR, 10); rd(W_CUR, 10, "R3 cur load"); rd(W_IVL, 32'hA5A5_0000, "R3 ivl kept");
    wr(W_CTL, 0);
    tick(0, 3); rd(W_CUR, 10, "R4 stopped holds");
    wr(W_CTL, 32'h1);
    tick(1, 3); rd(W_CUR, 10, "R5 fast ignored");
    tick(0, 3); rd(W_CUR, 7, "R4 slow counts");
    wr(W_CTL, 32'h5);
    tick(0, 2); rd(W_CUR, 7, "R5 slow ignored");
    tick(1, 2); rd(W_CUR, 5, "R5 fast counts");
    // R6 divide by 4
    wr(W_CUR, 100); wr(W_CTL, 32'h21);
    tick(0, 3); rd(W_CUR, 100, "R6 no dec before 4th");
    tick(0, 1); rd(W_CUR, 99, "R6 dec on 4th");
    tick(0, 8); rd(W_CUR, 97, "R6 two more");
    // R7/R8 periodic, first timeout differs from period
    wr(W_CTL, 0); wr(W_STS, 1); wr(W_IVL, 4); wr(W_CUR, 2); wr(W_CTL, 32'h3);
    tick(0, 1); chk_bit(irq_o, 1'b0, "R7 no expiry yet");
    tick(0, 1); chk_bit(irq_o, 1'b1, "R7 irq on expiry");
    rd(W_STS, 1, "R7 sts set"); rd(W_CUR, 4, "R8 reload"); rd(W_CTL, 3, "R8 still running");
    tick(0, 3); rd(W_CUR, 1, "R8 period count");
    tick(0, 1); rd(W_CUR, 4, "R8 second reload");
    // R10 write-1-to-clear
    wr(W_STS, 0); rd(W_STS, 1, "R10 write0 no effect");
    wr(W_STS, 1); rd(W_STS, 0, "R10 write1 clears");
    chk_bit(irq_o, 1'b0, "R11 irq low after clear");
    tick(0, 3);
    tick_wr(W_STS, 1);
    rd(W_STS, 1, "R10 set wins over clear"); rd(W_CUR, 4, "R8 reload on collision");
    // R11 gating
    chk_bit(irq_o, 1'b1, "R11 irq high");
    wr(W_IEN, 0); chk_bit(irq_o, 1'b0, "R11 masked");
    wr(W_IEN, 1); chk_bit(irq_o, 1'b1, "R11 unmasked");
    wr(W_STS, 1); chk_bit(irq_o, 1'b0, "R11 cleared");
    // R9 one-shot
    wr(W_CTL, 32'h1);
    tick(0, 4); chk_bit(irq_o, 1'b1, "R9 expiry irq");
    rd(W_CUR, 0, "R9 count zero"); rd(W_CTL, 0, "R9 run cleared"); rd(W_STS, 1, "R9 sts");
    tick(0, 3); rd(W_CUR, 0, "R9 stays stopped");
    // R12 load priority
    wr(W_STS, 1); wr(W_CTL, 32'h1); wr(W_CUR, 5);
    tick_wr(W_CUR, 9); rd(W_CUR, 9, "R12 load beats dec");
    wr(W_CUR, 1);
    tick_wr(W_CUR, 3);
    rd(W_STS, 0, "R12 no expiry on load"); rd(W_CUR, 3, "R12 loaded");
    rd(W_CTL, 1, "R12 run kept");
    // R7 expiry from zero count
    wr(W_CTL, 32'h3); wr(W_CUR, 0);
    tick(0, 1);
    rd(W_STS, 1, "R7 zero count expires"); rd(W_CUR, 4, "R8 reload from zero");
    repeat (3) @(negedge clk_i);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: got %0d pending reads exp 0", sb.size());
    end
    finish_run();
  end
endmodule